// File: doc/BRIEF.md
# Shared-Memory Slow Accumulator Bank

This block collects the overflow counts of many fast counters into one shared memory. Each fast counter has its own index, and that index selects one word of the memory. A fast counter sends its count as a dump request with its index and value. The bank then performs a read-add-write on that word over a two-stage pipeline, at a rate of one request per clock.

Each word also holds a small count of the dumps it has received. The dump that completes an integration is handled differently. The bank adds it to the word and rounds the sum to its upper `OUT_W` bits, using the bit just below those bits. It emits the rounded value together with the index on a result stream, and writes the word back as zero. The word therefore starts its next integration clean.

After reset the bank writes zero to every word, one word per clock. While this clearing pass runs, `req_ready` stays low and any request offered is dropped. Dump requests that arrive back to back for the same index are handled by forwarding the sum that was just written.

Top module: `acc_bank`

## Requirements
- R1: While reset is asserted, and for the clearing pass that follows it, `req_ready` and `res_valid` are 0. `req_ready` then rises, and every word reads as zero with a dump count of zero.
- R2: Each accepted request (`req_valid` and `req_ready` both 1 at a rising edge) adds `req_val`, zero-extended to `L_W` bits, to the word selected by `req_idx`. Only the `DUMPS_PER_INT`-th dump into a word produces a result.
- R3: The dump that completes an integration produces exactly one result. `res_valid` is 1 for one cycle, after the second rising edge that follows acceptance. `res_idx` equals the request's index.
- R4: `res_data` is bits [L_W-1 : L_W-OUT_W] of the final sum, plus bit L_W-OUT_W-1 of that sum (round half up).
- R5: If the rounding increment would carry out of `OUT_W` bits, `res_data` is all ones.
- R6: After a word's final dump, its next integration starts from a sum of zero and a count of zero.
- R7: Requests to the same index in consecutive cycles, or interleaved with other indices, each contribute exactly once.
- R8: A request changes only the word named by its index.
- R9: A request offered while `req_ready` is 0 has no effect on any word.
- R10: Once the clearing pass ends, `req_ready` stays 1 and a request is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A dump request is present |
| req_ready | output | 1 | The bank accepts requests |
| req_idx | input | IDX_W | Index of the word to update |
| req_val | input | DUMP_W | Dump value to add |
| res_valid | output | 1 | A result is present |
| res_idx | output | IDX_W | Index of the finished word |
| res_data | output | OUT_W | Rounded, saturated upper bits of the sum |

## Verification
A result is due two rising edges after its final dump is accepted, and is visible once the second of those edges has passed. The bench records the cycle number at each final dump and adds two to get the cycle the result is due. The monitor then requires each result to appear in exactly that cycle, with the expected index and value.

The expected values come from a per-index model of sums and dump counts. The bench also requires that no result appears when no result is due, which covers the non-final dumps. It also checks that `req_ready` is high at every dump it offers after the clearing pass.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned DEF_WORDS     = 2048;
  localparam int unsigned DEF_LOW_W     = 15;
  localparam int unsigned DEF_DUMP_W    = 13;
  localparam int unsigned DEF_OUT_W     = 8;
  localparam int unsigned DEF_PER_INT   = 4;
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned W     = 17,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/acc_round.sv
module acc_round #(
  parameter int unsigned IN_W  = 15,
  parameter int unsigned OUT_W = 8,
  localparam int unsigned SH   = IN_W - OUT_W
) (
  input  logic [IN_W-1:0]  sum,
  output logic [OUT_W-1:0] rounded
);
  logic [OUT_W-1:0] top;
  logic             half;
  logic [OUT_W:0]   wide;

  always_comb begin
    top     = sum[IN_W-1:SH];
    half    = sum[SH-1];
    wide    = {1'b0, top} + {{OUT_W{1'b0}}, half};
    rounded = wide[OUT_W] ? {OUT_W{1'b1}} : wide[OUT_W-1:0];
  end

  // R4: rounding never lowers the truncated value
  always_comb begin
    a_round_floor_r4: assert (rounded >= top);
  end
  // R5: a full top field stays full instead of wrapping
  always_comb begin
    a_sat_hold_r5: assert (!(&top) || (&rounded));
  end
endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
  parameter int unsigned N_WORDS       = acc_pkg::DEF_WORDS,
  parameter int unsigned L_W           = acc_pkg::DEF_LOW_W,
  parameter int unsigned DUMP_W        = acc_pkg::DEF_DUMP_W,
  parameter int unsigned OUT_W         = acc_pkg::DEF_OUT_W,
  parameter int unsigned DUMPS_PER_INT = acc_pkg::DEF_PER_INT,
  localparam int unsigned IDX_W        = $clog2(N_WORDS),
  localparam int unsigned CNT_W        = (DUMPS_PER_INT > 1) ? $clog2(DUMPS_PER_INT) : 1,
  localparam int unsigned MEM_W        = CNT_W + L_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [DUMP_W-1:0] req_val,
  output logic             res_valid,
  output logic [IDX_W-1:0] res_idx,
  output logic [OUT_W-1:0] res_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DUMPS_PER_INT - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // clearing pass state
  logic             sweep_q, sweep_d;
  logic [IDX_W-1:0] sweep_addr_q, sweep_addr_d;

  // pipeline state
  logic              s1_valid_q;
  logic [IDX_W-1:0]  s1_idx_q;
  logic [DUMP_W-1:0] s1_val_q;
  logic              fwd_valid_q;
  logic [IDX_W-1:0]  fwd_idx_q;
  logic [MEM_W-1:0]  fwd_word_q;
  logic              res_valid_q;
  logic [IDX_W-1:0]  res_idx_q;
  logic [OUT_W-1:0]  res_data_q;

  logic             accept;
  logic [MEM_W-1:0] rd_word, old_word, new_word, wr_word;
  logic [CNT_W-1:0] old_cnt;
  logic [L_W-1:0]   old_acc, new_acc;
  logic             is_last;
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [OUT_W-1:0] rnd_val;

  assign req_ready = ~sweep_q;
  assign accept    = req_valid & req_ready;

  // next state: clearing pass
  always_comb begin
    sweep_d      = sweep_q;
    sweep_addr_d = sweep_addr_q;
    if (sweep_q) begin
      sweep_addr_d = sweep_addr_q + 1'b1;
      if (sweep_addr_q == LAST_IDX) sweep_d = 1'b0;
    end
  end

  // stage 1: merge forwarded word, add, decide finish
  always_comb begin
    old_word = (fwd_valid_q && (fwd_idx_q == s1_idx_q)) ? fwd_word_q : rd_word;
    old_cnt  = old_word[MEM_W-1:L_W];
    old_acc  = old_word[L_W-1:0];
    new_acc  = old_acc + L_W'(s1_val_q);
    is_last  = (old_cnt == LAST_CNT);
    new_word = is_last ? '0 : {CNT_W'(old_cnt + 1'b1), new_acc};
  end

  // write port select
  always_comb begin
    wr_en   = sweep_q | s1_valid_q;
    wr_addr = sweep_q ? sweep_addr_q : s1_idx_q;
    wr_word = sweep_q ? '0 : new_word;
  end

  acc_mem #(.DEPTH(N_WORDS), .W(MEM_W)) u_mem (
    .clk     (clk),
    .rd_en   (accept),
    .rd_addr (req_idx),
    .rd_data (rd_word),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_word)
  );

  acc_round #(.IN_W(L_W), .OUT_W(OUT_W)) u_round (
    .sum     (new_acc),
    .rounded (rnd_val)
  );

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sweep_q      <= 1'b1;
      sweep_addr_q <= '0;
      s1_valid_q   <= 1'b0;
      s1_idx_q     <= '0;
      s1_val_q     <= '0;
      fwd_valid_q  <= 1'b0;
      fwd_idx_q    <= '0;
      fwd_word_q   <= '0;
      res_valid_q  <= 1'b0;
      res_idx_q    <= '0;
      res_data_q   <= '0;
    end else begin
      sweep_q      <= sweep_d;
      sweep_addr_q <= sweep_addr_d;
      s1_valid_q   <= accept;
      if (accept) begin
        s1_idx_q <= req_idx;
        s1_val_q <= req_val;
      end
      fwd_valid_q <= s1_valid_q;
      if (s1_valid_q) begin
        fwd_idx_q  <= s1_idx_q;
        fwd_word_q <= new_word;
      end
      res_valid_q <= s1_valid_q & is_last;
      if (s1_valid_q && is_last) begin
        res_idx_q  <= s1_idx_q;
        res_data_q <= rnd_val;
      end
    end
  end

  assign res_valid = res_valid_q;
  assign res_idx   = res_idx_q;
  assign res_data  = res_data_q;

  // R9: nothing enters the pipeline while not ready
  p_busy_drops_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_ready |=> !s1_valid_q);
  // R1: the clearing pass never shares the write port with an update
  p_port_excl_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(sweep_q && s1_valid_q));
  // R3: a result follows an accepted request by two edges
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> $past(req_valid && req_ready, 2));
  // R3: the result carries the index of that request
  p_index_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> (res_idx == $past(req_idx, 2)));
  // R10: ready never drops once the clearing pass ends
  p_ready_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |=> req_ready);
endmodule

// File: tb/sim_acc_bank.sv
module sim_acc_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NW  = 2048;
  localparam int LW  = 15;
  localparam int DW  = 13;
  localparam int OW  = 8;
  localparam int PER = 4;
  localparam int IW  = $clog2(NW);

  typedef struct {
    int    idx;
    int    data;
    int    due;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [IW-1:0] req_idx;
  logic [DW-1:0] req_val;
  logic          res_valid;
  logic [IW-1:0] res_idx;
  logic [OW-1:0] res_data;

  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  int   m_sum [NW];
  int   m_cnt [NW];
  exp_t q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acc_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_val(req_val),
    .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data)
  );

  function automatic int rnd(int s);
    int r;
    r = (s >> (LW - OW)) + ((s >> (LW - OW - 1)) & 1);
    if (r > (1 << OW) - 1) r = (1 << OW) - 1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int idx, input int val, input string tag);
    int due;
    @(negedge clk);
    req_valid = 1'b1;
    req_idx   = IW'(idx);
    req_val   = DW'(val);
    due       = cyc + 2;
    chk(req_ready === 1'b1, "R10 ready", int'(req_ready), 1);
    @(posedge clk);
    m_sum[idx] += val;
    m_cnt[idx] += 1;
    if (m_cnt[idx] == PER) begin
      q.push_back('{idx: idx, data: rnd(m_sum[idx]), due: due, tag: tag});
      m_sum[idx] = 0;
      m_cnt[idx] = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && res_valid === 1'b1) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2 unexpected result", int'(res_data), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.due, {e.tag, " timing"}, cyc, e.due);
        chk(int'(res_idx) == e.idx, {e.tag, " index"}, int'(res_idx), e.idx);
        chk(int'(res_data) == e.data, {e.tag, " data"}, int'(res_data), e.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit seen;
    for (int i = 0; i < NW; i++) begin
      m_sum[i] = 0;
      m_cnt[i] = 0;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_idx = '0; req_val = '0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b0, "R1 ready in reset", int'(req_ready), 0);
    chk(res_valid === 1'b0, "R1 result in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    // R9: offers during the clearing pass must be dropped
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_idx = IW'(5); req_val = DW'(1000);
      chk(req_ready === 1'b0, "R9 ready low while clearing", int'(req_ready), 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < NW + 20 && !seen; i++) begin
      @(negedge clk);
      if (req_ready === 1'b1) seen = 1'b1;
    end
    chk(seen, "R1 ready after clearing", int'(seen), 1);

    // R4 rounding on small sums
    send(10, 100, "R4"); send(10, 27, "R4"); send(10, 0, "R4"); send(10, 1, "R4");
    send(11, 30, "R4");  send(11, 30, "R4"); send(11, 4, "R4"); send(11, 0, "R4");
    send(12, 63, "R4");  send(12, 0, "R4");  send(12, 0, "R4"); send(12, 0, "R4");
    idle(2);
    // R5 saturation and the values around it
    send(13, 8191, "R5"); send(13, 8191, "R5"); send(13, 8191, "R5"); send(13, 8131, "R5");
    send(14, 8191, "R5"); send(14, 8191, "R5"); send(14, 8191, "R5"); send(14, 8130, "R5");
    send(15, 8100, "R5"); send(15, 8100, "R5"); send(15, 8100, "R5"); send(15, 8100, "R5");
    idle(3);
    // R7 back to back on one index
    send(20, 1000, "R7"); send(20, 2000, "R7"); send(20, 3000, "R7"); send(20, 4000, "R7");
    // R7 interleaved
    send(21, 700, "R7"); send(21, 900, "R7"); send(22, 50, "R7"); send(21, 3000, "R7");
    send(22, 6000, "R7"); send(21, 11, "R7"); send(22, 77, "R7"); send(22, 4095, "R7");
    idle(2);
    // R6 restart after clear on an index already used
    send(20, 64, "R6"); send(20, 64, "R6"); send(20, 64, "R6"); send(20, 64, "R6");
    // R9 index 5 must not hold the dropped offers
    send(5, 128, "R9"); send(5, 128, "R9"); send(5, 128, "R9"); send(5, 128, "R9");
    // R1 cleared words, including the last index
    send(7, 0, "R1"); send(7, 0, "R1"); send(7, 0, "R1"); send(7, 0, "R1");
    send(NW - 1, 500, "R1"); send(NW - 1, 500, "R1");
    send(NW - 1, 500, "R1"); send(NW - 1, 500, "R1");
    // R8 many words in one stream, plus R2 counting
    for (int i = 0; i < 60; i++) send(30 + (i % 3), (i * 37 + 11) % 4096, "R8");
    idle(6);
    chk(q.size() == 0, "R3 all results delivered", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule